// File: doc/BRIEF.md
# Multi-cycle reciprocal frequency meter

This block measures the frequency of a digital pulse train against a fast reference clock. It does not count pulses inside a fixed gate. It times a whole number of input periods instead. Timing starts on a debounced rising edge. The block keeps counting input cycles until the elapsed reference time has reached a programmable minimum window. It stops on the first rising edge after that point. The cycle count N and the tick count T are then passed to a sequential divider, which produces `N * scale / T`. The result is clipped to a 12-bit code. Software chooses `scale`, so the highest expected frequency maps to full scale on any range. A larger window gives finer resolution and a slower update.

The raw input first passes through a two-stage synchronizer. It then goes through a stability filter, so relay or switch chatter is not counted as edges. If the input stops toggling, a timeout of twice the window reports a zero code with a no-signal flag. Each result, measured or timed out, is marked by a single-cycle valid strobe.

Top module: `recip_freq_meter`

## Requirements
- R1: While reset is held and after its release, `valid_o`, `no_signal_o` and `code_o` are all zero until the first result.
- R2: The filtered level takes a new value only after the synchronized input has held that value for `cfg_debounce_i + 1` consecutive clock cycles. A high pulse or a low dropout lasting `cfg_debounce_i` cycles or fewer is ignored and does not change the measured code.
- R3: A measurement starts at a filtered rising edge while idle. Its code is `floor(N * cfg_scale_i / T)`, where N is the number of complete input periods timed and T is the number of reference cycles between the first and the last rising edge.
- R4: The measurement ends on the first filtered rising edge at which T is at least `cfg_window_i`. An edge that reaches the window exactly ends it.
- R5: When the quotient exceeds 4095, `code_o` is 4095.
- R6: If no filtered rising edge arrives for `2 * cfg_window_i` cycles while idle or timing, the block issues a result with `code_o` = 0 and `no_signal_o` = 1. The count runs from the last edge.
- R7: `valid_o` is high for exactly one cycle per result. `code_o` changes only in a cycle where `valid_o` is high.
- R8: A measured result clears `no_signal_o` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pulse_i | input | 1 | Raw pulse input, asynchronous |
| cfg_debounce_i | input | DEB_W | Stability time in reference cycles, minus one |
| cfg_window_i | input | TICK_W | Minimum measurement window in reference cycles |
| cfg_scale_i | input | SCALE_W | Range scale factor applied to N / T |
| code_o | output | 12 | Scaled frequency code |
| valid_o | output | 1 | One-cycle strobe for a new result |
| no_signal_o | output | 1 | Set when the last result came from a timeout |

## Verification
The hardest case to reach is a measurement whose stopping edge is decided by an uneven edge spacing. This includes a cumulative time that lands exactly on the window, and a rising edge that arrives while the divider is still busy. A periodic generator cannot produce these cases. The bench therefore stops the free-running generator and waits for an idle timeout, so the meter is known to be idle. It then drives hand-built gap sequences and predicts N and T by summing the gaps. The trailing edge of each sequence starts a measurement that is left to time out, which exercises the no-signal path and its latency.

// File: rtl/fm_pkg.sv
package fm_pkg;
  localparam int CODE_W   = 12;
  localparam int CODE_MAX = (1 << CODE_W) - 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } meas_state_e;
endpackage

// File: rtl/fm_debounce.sv
module fm_debounce #(
  parameter int DEB_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw_i,
  input  logic [DEB_W-1:0] hold_i,
  output logic             sync_o,
  output logic             level_o
);
  logic             sync_a, sync_b, level_q;
  logic [DEB_W-1:0] stable_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a     <= 1'b0;
      sync_b     <= 1'b0;
      level_q    <= 1'b0;
      stable_cnt <= '0;
    end else begin
      sync_a <= raw_i;
      sync_b <= sync_a;
      if (sync_b == level_q) begin
        stable_cnt <= '0;
      end else if (stable_cnt >= hold_i) begin
        level_q    <= sync_b;
        stable_cnt <= '0;
      end else begin
        stable_cnt <= stable_cnt + 1'b1;
      end
    end
  end

  assign sync_o  = sync_b;
  assign level_o = level_q;
endmodule

// File: rtl/fm_period_timer.sv
module fm_period_timer
  import fm_pkg::*;
#(
  parameter int TICK_W = 20,
  parameter int CYC_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              level_i,
  input  logic [TICK_W-1:0] window_i,
  input  logic              div_done_i,
  output logic              stop_o,
  output logic [CYC_W-1:0]  cycles_o,
  output logic [TICK_W-1:0] ticks_o,
  output logic              timeout_o
);
  localparam int LIM_W = TICK_W + 1;
  localparam logic [TICK_W-1:0] TICK_MAX = {TICK_W{1'b1}};
  localparam logic [CYC_W-1:0]  CYC_MAX  = {CYC_W{1'b1}};

  meas_state_e       state;
  logic              level_d;
  logic [TICK_W-1:0] ticks;
  logic [CYC_W-1:0]  cycles;
  logic [LIM_W-1:0]  idle_cnt;

  logic              rise;
  logic [TICK_W-1:0] elapsed;
  logic [CYC_W-1:0]  cycles_nx;
  logic [LIM_W-1:0]  limit, idle_nx;
  logic              window_met;

  assign rise       = level_i & ~level_d;
  assign elapsed    = (ticks == TICK_MAX) ? ticks : ticks + 1'b1;
  assign cycles_nx  = cycles + 1'b1;
  assign window_met = (elapsed >= window_i) || (cycles_nx == CYC_MAX);
  assign limit      = {window_i, 1'b0};
  assign idle_nx    = idle_cnt + 1'b1;

  assign stop_o    = (state == ST_RUN) && rise && window_met;
  assign cycles_o  = cycles_nx;
  assign ticks_o   = elapsed;
  assign timeout_o = (state != ST_HOLD) && !rise && (limit != '0) && (idle_nx == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      level_d  <= 1'b0;
      ticks    <= '0;
      cycles   <= '0;
      idle_cnt <= '0;
    end else begin
      level_d <= level_i;
      case (state)
        ST_IDLE: begin
          if (rise) begin
            state    <= ST_RUN;
            ticks    <= '0;
            cycles   <= '0;
            idle_cnt <= '0;
          end else if (timeout_o) begin
            idle_cnt <= '0;
          end else begin
            idle_cnt <= idle_nx;
          end
        end
        ST_RUN: begin
          ticks <= elapsed;
          if (rise) begin
            idle_cnt <= '0;
            if (window_met) state <= ST_HOLD;
            else cycles <= cycles_nx;
          end else if (timeout_o) begin
            state    <= ST_IDLE;
            idle_cnt <= '0;
          end else begin
            idle_cnt <= idle_nx;
          end
        end
        default: begin
          idle_cnt <= '0;
          if (div_done_i) state <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/fm_divider.sv
module fm_divider #(
  parameter int NUM_W = 32,
  parameter int DEN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quot_o
);
  localparam int STEP_W = $clog2(NUM_W + 1);

  // One restoring step: returns {quotient bit, new remainder}.
  function automatic logic [DEN_W:0] div_step(input logic [DEN_W-1:0] rem,
                                              input logic bit_in,
                                              input logic [DEN_W-1:0] den);
    logic [DEN_W:0] trial;
    trial = {rem, bit_in};
    if (trial >= {1'b0, den}) return {1'b1, DEN_W'(trial - {1'b0, den})};
    else                      return {1'b0, trial[DEN_W-1:0]};
  endfunction

  logic             busy;
  logic [STEP_W-1:0] steps;
  logic [NUM_W-1:0] acc;
  logic [DEN_W-1:0] rem, den_q;
  logic [DEN_W:0]   step_res;

  always_comb step_res = div_step(rem, acc[NUM_W-1], den_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      steps  <= '0;
      acc    <= '0;
      rem    <= '0;
      den_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        busy  <= 1'b1;
        steps <= STEP_W'(NUM_W);
        acc   <= num_i;
        rem   <= '0;
        den_q <= den_i;
      end else if (busy) begin
        acc   <= {acc[NUM_W-2:0], step_res[DEN_W]};
        rem   <= step_res[DEN_W-1:0];
        steps <= steps - 1'b1;
        if (steps == STEP_W'(1)) begin
          busy   <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign quot_o = acc;
endmodule

// File: rtl/recip_freq_meter.sv
module recip_freq_meter
  import fm_pkg::*;
#(
  parameter int TICK_W  = 20,
  parameter int CYC_W   = 12,
  parameter int SCALE_W = 20,
  parameter int DEB_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pulse_i,
  input  logic [DEB_W-1:0]   cfg_debounce_i,
  input  logic [TICK_W-1:0]  cfg_window_i,
  input  logic [SCALE_W-1:0] cfg_scale_i,
  output logic [CODE_W-1:0]  code_o,
  output logic               valid_o,
  output logic               no_signal_o
);
  localparam int NUM_W = CYC_W + SCALE_W;

  function automatic logic [CODE_W-1:0] clip_code(input logic [NUM_W-1:0] q);
    if (q > NUM_W'(CODE_MAX)) return CODE_W'(CODE_MAX);
    else                      return q[CODE_W-1:0];
  endfunction

  logic              in_sync, in_level;
  logic              meas_stop, meas_timeout, div_done;
  logic [CYC_W-1:0]  meas_cycles;
  logic [TICK_W-1:0] meas_ticks;
  logic [NUM_W-1:0]  div_num, div_quot;

  fm_debounce #(.DEB_W(DEB_W)) u_deb (
    .clk(clk), .rst_n(rst_n), .raw_i(pulse_i), .hold_i(cfg_debounce_i),
    .sync_o(in_sync), .level_o(in_level)
  );

  fm_period_timer #(.TICK_W(TICK_W), .CYC_W(CYC_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .level_i(in_level), .window_i(cfg_window_i),
    .div_done_i(div_done), .stop_o(meas_stop), .cycles_o(meas_cycles),
    .ticks_o(meas_ticks), .timeout_o(meas_timeout)
  );

  assign div_num = NUM_W'(meas_cycles) * NUM_W'(cfg_scale_i);

  fm_divider #(.NUM_W(NUM_W), .DEN_W(TICK_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start_i(meas_stop), .num_i(div_num),
    .den_i(meas_ticks), .done_o(div_done), .quot_o(div_quot)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_o      <= '0;
      valid_o     <= 1'b0;
      no_signal_o <= 1'b0;
    end else begin
      valid_o <= div_done | meas_timeout;
      if (div_done) begin
        code_o      <= clip_code(div_quot);
        no_signal_o <= 1'b0;
      end else if (meas_timeout) begin
        code_o      <= '0;
        no_signal_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fm_checker.sv
module fm_checker #(
  parameter int TICK_W = 20,
  parameter int CYC_W  = 12,
  parameter int NUM_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sync_lvl,
  input logic              filt_lvl,
  input logic              meas_stop,
  input logic [CYC_W-1:0]  meas_cycles,
  input logic [TICK_W-1:0] meas_ticks,
  input logic [TICK_W-1:0] window,
  input logic              meas_timeout,
  input logic              div_done,
  input logic [NUM_W-1:0]  div_quot,
  input logic [11:0]       code,
  input logic              valid,
  input logic              no_signal
);
  p_filter_follows_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_lvl != $past(filt_lvl)) |-> ($past(sync_lvl) == filt_lvl));

  p_stop_after_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    meas_stop |-> (meas_ticks >= window || meas_cycles == {CYC_W{1'b1}}));

  p_saturate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (div_done && div_quot > NUM_W'(4095)) |=> (code == 12'd4095));

  p_timeout_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
    meas_timeout |=> (valid && no_signal && code == 12'd0));

  p_nosig_zero_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    no_signal |-> (code == 12'd0));

  p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  p_code_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> $stable(code));

  p_measured_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    div_done |=> (valid && !no_signal));
endmodule

bind recip_freq_meter fm_checker #(
  .TICK_W(TICK_W), .CYC_W(CYC_W), .NUM_W(NUM_W)
) u_fm_checker (
  .clk(clk), .rst_n(rst_n), .sync_lvl(in_sync), .filt_lvl(in_level),
  .meas_stop(meas_stop), .meas_cycles(meas_cycles), .meas_ticks(meas_ticks),
  .window(cfg_window_i), .meas_timeout(meas_timeout), .div_done(div_done),
  .div_quot(div_quot), .code(code_o), .valid(valid_o), .no_signal(no_signal_o)
);

// File: tb/test_recip_freq_meter.sv
module test_recip_freq_meter;
  localparam int TICK_W = 20, CYC_W = 12, SCALE_W = 20, DEB_W = 16;
  localparam int DEB = 3, WIN = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic gen_raw = 1'b0, seq_raw = 1'b0, pulse;
  logic [DEB_W-1:0]   cfg_deb = DEB_W'(DEB);
  logic [TICK_W-1:0]  cfg_win = TICK_W'(WIN);
  logic [SCALE_W-1:0] cfg_scale = '0;
  logic [11:0] code;
  logic valid, nosig;

  assign pulse = gen_raw | seq_raw;
  always #2 clk = ~clk;

  recip_freq_meter i_recip_freq_meter (
    .clk(clk), .rst_n(rst_n), .pulse_i(pulse), .cfg_debounce_i(cfg_deb),
    .cfg_window_i(cfg_win), .cfg_scale_i(cfg_scale), .code_o(code),
    .valid_o(valid), .no_signal_o(nosig)
  );

  int n_checks = 0, n_fail = 0, cyc = 0;
  int vcount = 0, dbl = 0;
  int res_code [0:1023];
  bit res_ns   [0:1023];
  int res_cyc  [0:1023];
  bit prev_v = 1'b0;
  int gen_hi = 4, gen_lo = 4;
  bit gen_on = 1'b0, gen_glitch = 1'b0;
  int last_rise = 0;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (rst_n) begin
      if (valid) begin
        res_code[vcount % 1024] = code;
        res_ns[vcount % 1024]   = nosig;
        res_cyc[vcount % 1024]  = cyc;
        vcount++;
      end
      if (valid && prev_v) dbl++;
      prev_v = valid;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_results(input int target);
    while (vcount < target) @(negedge clk);
  endtask

  // Free-running generator; glitch mode adds a D-cycle blip in each phase.
  initial begin
    forever begin
      if (gen_on) begin
        int h, l;
        bit g;
        h = gen_hi; l = gen_lo; g = gen_glitch;
        if (g) begin
          gen_raw = 1; repeat (4) @(negedge clk);
          gen_raw = 0; repeat (DEB) @(negedge clk);
          gen_raw = 1; repeat (h - 4 - DEB) @(negedge clk);
          gen_raw = 0; repeat (4) @(negedge clk);
          gen_raw = 1; repeat (DEB) @(negedge clk);
          gen_raw = 0; repeat (l - 4 - DEB) @(negedge clk);
        end else begin
          gen_raw = 1; repeat (h) @(negedge clk);
          gen_raw = 0; repeat (l) @(negedge clk);
        end
      end else begin
        gen_raw = 0;
        @(negedge clk);
      end
    end
  end

  task automatic periodic_point(input int per, input int scale, input bit glitch, input string req);
    int idx0, exp;
    cfg_scale = SCALE_W'(scale);
    gen_glitch = glitch;
    gen_hi = glitch ? 11 : per / 2;
    gen_lo = per - gen_hi;
    gen_on = 1;
    idx0 = vcount;
    wait_results(idx0 + 2);
    exp = scale / per;
    if (exp > 4095) exp = 4095;
    check(res_code[(idx0 + 1) % 1024] == exp && !res_ns[(idx0 + 1) % 1024], req,
          res_code[(idx0 + 1) % 1024], exp);
  endtask

  task automatic drive_seq(input int gaps[6], input int cnt);
    for (int i = 0; i <= cnt; i++) begin
      seq_raw = 1; last_rise = cyc;
      repeat (4) @(negedge clk);
      seq_raw = 0;
      repeat ((i < cnt) ? gaps[i] - 4 : 4) @(negedge clk);
    end
  endtask

  task automatic seq_case(input int gaps[6], input int cnt, input int scale);
    int sum, k, t, exp, idx0, dt;
    sum = 0; k = 0; t = 0;
    for (int i = 0; i < cnt; i++) begin
      sum += gaps[i];
      if (k == 0 && sum >= WIN) begin k = i + 1; t = sum; end
    end
    exp = (k * scale) / t;
    if (exp > 4095) exp = 4095;
    cfg_scale = SCALE_W'(scale);
    // Synchronise to an idle timeout so the meter is idle at the first edge.
    idx0 = vcount;
    wait_results(idx0 + 1);
    idx0 = vcount;
    drive_seq(gaps, cnt);
    wait_results(idx0 + 2);
    // R3/R4: stopping edge set by cumulative gaps reaching the window
    check(res_code[idx0 % 1024] == exp && !res_ns[idx0 % 1024], "R4", res_code[idx0 % 1024], exp);
    // R6: trailing edge starts a measurement that times out
    check(res_ns[(idx0 + 1) % 1024] && res_code[(idx0 + 1) % 1024] == 0, "R6",
          res_code[(idx0 + 1) % 1024], 0);
    dt = res_cyc[(idx0 + 1) % 1024] - last_rise;
    check(dt >= 2 * WIN && dt <= 2 * WIN + 20, "R6", dt, 2 * WIN);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(code == 0 && !valid && !nosig, "R1", code, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(code == 0 && !valid && !nosig, "R1", {nosig, valid, code}, 0);

    // R3, R5: periodic sweep over several ranges; 4-cycle phases sit at the R2 boundary
    for (int p = 8; p <= 60; p += 4) begin
      periodic_point(p, 1000, 0, "R3");
      periodic_point(p, 40000, 0, "R5");
      periodic_point(p, 100000, 0, "R3");
    end
    // R2: blips and dropouts of exactly cfg_debounce cycles must not alter the code
    for (int p = 24; p <= 60; p += 4) periodic_point(p, 60000, 1, "R2");

    gen_on = 0;
    begin
      int s1[6] = '{30, 50, 70, 40, 90, 60};
      int s2[6] = '{100, 100, 100, 8, 8, 8};
      int s3[6] = '{150, 20, 20, 20, 20, 50};
      seq_case(s1, 6, 100000);
      seq_case(s2, 3, 100000);
      seq_case(s3, 6, 100000);
    end

    // R8: a measured result after a timeout clears the flag
    check(res_ns[(vcount - 1) % 1024] == 1, "R6", res_ns[(vcount - 1) % 1024], 1);
    periodic_point(20, 50000, 0, "R8");

    check(dbl == 0, "R7", dbl, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule